// File: doc/BRIEF.md
# ATA Register Cycle Sequencer

This block is the host-side engine that runs one register read or register write cycle at a time on a parallel ATA bus. A command port hands it a block select (command block or control block), a 3-bit register address, a direction flag and a write byte. The block then drives the two active-low block selects and the address lines, opens an active-low read or write strobe, and closes the strobe. It holds the address through recovery and returns the read byte with a one-cycle done pulse.

Every phase minimum is given in nanoseconds and turned into a count of system clock cycles by rounding up against a clock-period parameter. The device can stretch the strobe by pulling the ready line low. That line is looked at once, a fixed delay after the strobe opens. A stall counter ends a strobe that the device never releases and flags the result as an error. The DMA acknowledge output is held inactive.

Top module: `ata_reg_xfer`

## Requirements
- R1: In reset and after reset, both block selects, both strobes and the DMA acknowledge are high, the data drive enable is low, `cmd_ready` is high and `rsp_done` is low.
- R2: `cmd_blk`=0 drives `ata_cmdblk_sel_n` low and `cmd_blk`=1 drives `ata_ctlblk_sel_n` low. `ata_addr` equals `cmd_reg`. Select and address stay unchanged from the first cycle of the access until release.
- R3: Address and select are valid for exactly ceil(T_SETUP_NS/CLK_PERIOD_NS) cycles (125 at defaults) before the strobe goes low.
- R4: With no wait, the strobe is low for exactly ceil(T_PULSE_NS/CLK_PERIOD_NS) cycles (38 at defaults).
- R5: The ready line is sampled in strobe cycle S = ceil(T_RDY_NS/CLK_PERIOD_NS) (5 at defaults). If it is low there, the strobe stays low until the cycle in which ready is seen high, and never shorter than R4. Ready that is low only before cycle S has no effect.
- R6: If ready stays low for WAIT_LIMIT consecutive sampled cycles, the strobe is closed after strobe cycle S+WAIT_LIMIT-1 and `rsp_err` is 1 with the done pulse. Otherwise `rsp_err` is 0.
- R7: After the strobe closes, select and address are held for max(ceil(T_RECOV_NS/T), ceil(T_HOLD_NS/T), ceil(T_CYCLE_NS/T) minus setup minus pulse) cycles (113 at defaults). The whole access is at least T_CYCLE_NS.
- R8: On a write, `ata_doe` is high and `ata_dout` carries `cmd_wdata` for as long as the select is active. On a read, and while idle, `ata_doe` is low.
- R9: Read data is taken from `ata_din` at the clock edge that raises the read strobe. `rsp_done` is high for exactly one cycle, the second cycle after the strobe rises.
- R10: `dma_ack_n` stays high at all times.
- R11: While an access is in progress `cmd_ready` is low and `cmd_valid` is ignored. `cmd_ready` returns high in the cycle the select is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle; a request is accepted when both are high |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_blk | input | 1 | 0 = command block, 1 = control block |
| cmd_reg | input | 3 | Register address within the block |
| cmd_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read from the device |
| rsp_err | output | 1 | Access was ended by the stall limit |
| ata_cmdblk_sel_n | output | 1 | Command block select, active low |
| ata_ctlblk_sel_n | output | 1 | Control block select, active low |
| ata_addr | output | 3 | Register address lines |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dout | output | 8 | Low data byte to the bus |
| ata_doe | output | 1 | Drive enable for the low data byte |
| ata_din | input | 8 | Low data byte from the bus |
| ata_rdy | input | 1 | Device ready; low requests a wait |
| dma_ack_n | output | 1 | DMA acknowledge, held inactive |

## Verification
The select goes active on the edge that accepts the command. The strobe then opens after the setup count. It closes after the pulse count, or after the first ready-high cycle once a wait has begun. The done pulse is seen on the second sampling point after the strobe rises, and the select drops after the recovery count. The bench samples on the falling clock edge and counts, for each access, how many samples fall in each phase. It compares those counts with values it derives by ceiling division from the nanosecond minimums. It also drives the ready line by strobe-cycle number, so that the expected strobe length follows from the sample cycle, the hold-off length and the stall limit.

// File: rtl/ata_reg_pkg.sv
package ata_reg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  // ceiling conversion of a nanosecond minimum to clock cycles
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ata_phase_cnt.sv
module ata_phase_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ata_rdy_gate.sv
module ata_rdy_gate
  import ata_reg_pkg::*;
#(
  parameter int SAMP_CYC  = 5,
  parameter int PULSE_CYC = 38,
  parameter int LIMIT_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic rdy,
  output logic stall,
  output logic abort,
  output logic pulse_met
);
  localparam int EL_TOP = imax(SAMP_CYC, PULSE_CYC) - 1;
  localparam int ELW    = $clog2(EL_TOP + 2);
  localparam int LW     = $clog2(LIMIT_CYC + 1);

  logic [ELW-1:0] el;
  logic           waiting;
  logic [LW-1:0]  wcnt;

  assign stall     = active && !rdy && (waiting || (el == ELW'(SAMP_CYC - 1)));
  assign abort     = stall && (wcnt == LW'(LIMIT_CYC - 1));
  assign pulse_met = (el >= ELW'(PULSE_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      el      <= '0;
      waiting <= 1'b0;
      wcnt    <= '0;
    end else begin
      if (el != ELW'(EL_TOP)) el <= el + 1'b1;
      waiting <= stall;
      wcnt    <= stall ? wcnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/ata_reg_xfer.sv
module ata_reg_xfer
  import ata_reg_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_SETUP_NS    = 1000,
  parameter int T_PULSE_NS    = 300,
  parameter int T_RECOV_NS    = 900,
  parameter int T_HOLD_NS     = 900,
  parameter int T_CYCLE_NS    = 2000,
  parameter int T_RDY_NS      = 35,
  parameter int WAIT_LIMIT    = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic       cmd_write,
  input  logic       cmd_blk,
  input  logic [2:0] cmd_reg,
  input  logic [7:0] cmd_wdata,
  output logic       rsp_done,
  output logic [7:0] rsp_rdata,
  output logic       rsp_err,
  output logic       ata_cmdblk_sel_n,
  output logic       ata_ctlblk_sel_n,
  output logic [2:0] ata_addr,
  output logic       ata_rd_n,
  output logic       ata_wr_n,
  output logic [7:0] ata_dout,
  output logic       ata_doe,
  input  logic [7:0] ata_din,
  input  logic       ata_rdy,
  output logic       dma_ack_n
);
  localparam int SETUP_CYC = imax(1, ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS));
  localparam int PULSE_CYC = imax(1, ns_to_cyc(T_PULSE_NS, CLK_PERIOD_NS));
  localparam int SAMP_CYC  = imax(1, ns_to_cyc(T_RDY_NS, CLK_PERIOD_NS));
  localparam int FILL_CYC  = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS) - SETUP_CYC - PULSE_CYC;
  localparam int REC_CYC   = imax(1, imax(FILL_CYC,
                               imax(ns_to_cyc(T_RECOV_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_HOLD_NS, CLK_PERIOD_NS))));
  localparam int CW        = $clog2(imax(SETUP_CYC, REC_CYC) + 1);

  phase_e     phase;
  logic       op_write;
  logic       accept;
  logic       strobe_exit;
  logic       cnt_load;
  logic [CW-1:0] cnt_val;
  logic       cnt_zero;
  logic       stall, abort, pulse_met;
  logic       done_pend;

  assign accept      = (phase == PH_IDLE) && cmd_valid && cmd_ready;
  assign strobe_exit = (phase == PH_STROBE) && (abort || (pulse_met && !stall));
  assign cnt_load    = accept || strobe_exit;
  assign cnt_val     = (phase == PH_IDLE) ? CW'(SETUP_CYC - 1) : CW'(REC_CYC - 1);

  ata_phase_cnt #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  ata_rdy_gate #(
    .SAMP_CYC  (SAMP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .LIMIT_CYC (WAIT_LIMIT)
  ) u_gate (
    .clk       (clk),
    .rst       (rst),
    .active    (phase == PH_STROBE),
    .rdy       (ata_rdy),
    .stall     (stall),
    .abort     (abort),
    .pulse_met (pulse_met)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase            <= PH_IDLE;
      op_write         <= 1'b0;
      cmd_ready        <= 1'b1;
      rsp_done         <= 1'b0;
      rsp_rdata        <= '0;
      rsp_err          <= 1'b0;
      done_pend        <= 1'b0;
      ata_cmdblk_sel_n <= 1'b1;
      ata_ctlblk_sel_n <= 1'b1;
      ata_addr         <= '0;
      ata_rd_n         <= 1'b1;
      ata_wr_n         <= 1'b1;
      ata_dout         <= '0;
      ata_doe          <= 1'b0;
      dma_ack_n        <= 1'b1;
    end else begin
      done_pend <= 1'b0;
      rsp_done  <= done_pend;
      dma_ack_n <= 1'b1;
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            op_write         <= cmd_write;
            ata_cmdblk_sel_n <= cmd_blk;
            ata_ctlblk_sel_n <= !cmd_blk;
            ata_addr         <= cmd_reg;
            ata_dout         <= cmd_wdata;
            ata_doe          <= cmd_write;
            cmd_ready        <= 1'b0;
            phase            <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            if (op_write) ata_wr_n <= 1'b0;
            else          ata_rd_n <= 1'b0;
            phase <= PH_STROBE;
          end
        end
        PH_STROBE: begin
          if (strobe_exit) begin
            ata_rd_n  <= 1'b1;
            ata_wr_n  <= 1'b1;
            if (!op_write) rsp_rdata <= ata_din;
            rsp_err   <= abort;
            done_pend <= 1'b1;
            phase     <= PH_RECOV;
          end
        end
        PH_RECOV: begin
          if (cnt_zero) begin
            ata_cmdblk_sel_n <= 1'b1;
            ata_ctlblk_sel_n <= 1'b1;
            ata_doe          <= 1'b0;
            cmd_ready        <= 1'b1;
            phase            <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_reg_xfer_chk.sv
module ata_reg_xfer_chk #(
  parameter int SETUP_CYC = 125
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_ready,
  input logic       rsp_done,
  input logic       cmd_sel_n,
  input logic       ctl_sel_n,
  input logic [2:0] addr,
  input logic       rd_n,
  input logic       wr_n,
  input logic       doe
);
  logic sel, stb;
  int   su_cnt;

  assign sel = !cmd_sel_n || !ctl_sel_n;
  assign stb = !rd_n || !wr_n;

  always_ff @(posedge clk) begin
    if (rst || !sel)        su_cnt <= 0;
    else if (!stb && su_cnt < SETUP_CYC) su_cnt <= su_cnt + 1;
  end

  // R2
  sel_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && $past(sel)) |-> ($stable(addr) && $stable(cmd_sel_n) && $stable(ctl_sel_n)));

  // R2
  one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !(!cmd_sel_n && !ctl_sel_n));

  // R3
  setup_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stb) |-> (sel && su_cnt >= SETUP_CYC));

  // R8
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (doe && rd_n));

  // R8
  rd_float_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !doe);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R9
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (rd_n && wr_n && $past(rd_n && wr_n) && !$past(rd_n && wr_n, 2)));

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    stb |-> !cmd_ready);
endmodule

bind ata_reg_xfer ata_reg_xfer_chk #(.SETUP_CYC(SETUP_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ready (cmd_ready),
  .rsp_done  (rsp_done),
  .cmd_sel_n (ata_cmdblk_sel_n),
  .ctl_sel_n (ata_ctlblk_sel_n),
  .addr      (ata_addr),
  .rd_n      (ata_rd_n),
  .wr_n      (ata_wr_n),
  .doe       (ata_doe)
);

// File: tb/sim_ata_reg_xfer.sv
`timescale 1ns/1ps
module sim_ata_reg_xfer;
  localparam int TCK   = 8;
  localparam int TSU   = 1000;
  localparam int TPW   = 300;
  localparam int TREC  = 900;
  localparam int THLD  = 900;
  localparam int TCYC  = 2000;
  localparam int TRDY  = 35;
  localparam int LIMIT = 1000;

  localparam int E_SU   = (TSU + TCK - 1) / TCK;
  localparam int E_PW   = (TPW + TCK - 1) / TCK;
  localparam int E_SAMP = (TRDY + TCK - 1) / TCK;
  localparam int E_R1   = (TREC + TCK - 1) / TCK;
  localparam int E_R2   = (THLD + TCK - 1) / TCK;
  localparam int E_R3   = (TCYC + TCK - 1) / TCK - E_SU - E_PW;
  localparam int E_HD   = (E_R1 > E_R2) ? ((E_R1 > E_R3) ? E_R1 : E_R3)
                                        : ((E_R2 > E_R3) ? E_R2 : E_R3);

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_write = 0, cmd_blk = 0;
  logic [2:0] cmd_reg = 0;
  logic [7:0] cmd_wdata = 0, ata_din = 0;
  logic ata_rdy = 1;
  logic cmd_ready, rsp_done, rsp_err;
  logic [7:0] rsp_rdata, ata_dout;
  logic ata_cmdblk_sel_n, ata_ctlblk_sel_n, ata_rd_n, ata_wr_n, ata_doe, dma_ack_n;
  logic [2:0] ata_addr;

  int checks = 0, fails = 0, cyc = 0;

  always #(TCK/2) clk = ~clk;

  ata_reg_xfer #(
    .CLK_PERIOD_NS(TCK), .T_SETUP_NS(TSU), .T_PULSE_NS(TPW), .T_RECOV_NS(TREC),
    .T_HOLD_NS(THLD), .T_CYCLE_NS(TCYC), .T_RDY_NS(TRDY), .WAIT_LIMIT(LIMIT)
  ) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_blk(cmd_blk), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ata_cmdblk_sel_n(ata_cmdblk_sel_n), .ata_ctlblk_sel_n(ata_ctlblk_sel_n),
    .ata_addr(ata_addr), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
    .ata_dout(ata_dout), .ata_doe(ata_doe), .ata_din(ata_din), .ata_rdy(ata_rdy),
    .dma_ack_n(dma_ack_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus monitor and device model, sampled on the falling edge
  int  ph = 0, su, pw, hd, done_hd, done_n, rdy_hold = 0;
  bit  fin = 0, sel_chg, doe_bad, dack_bad = 0, exp_doe, saw_rd, saw_wr;
  bit  got_err, s_cmd, s_ctl;
  logic [2:0] s_addr;
  logic [7:0] got_rdata, wd_seen;

  always @(negedge clk) begin
    if (!rst) begin
      automatic bit sel = !ata_cmdblk_sel_n || !ata_ctlblk_sel_n;
      automatic bit stb = !ata_rd_n || !ata_wr_n;
      if (dma_ack_n !== 1'b1) dack_bad = 1;
      if (stb) begin pw++; ata_rdy = (pw > rdy_hold); end
      else ata_rdy = 1;
      if (ph == 0 && sel) begin
        ph = 1; su = 0; pw = 0; hd = 0; done_hd = -1; done_n = 0; sel_chg = 0;
        doe_bad = 0; saw_rd = 0; saw_wr = 0;
        s_cmd = ata_cmdblk_sel_n; s_ctl = ata_ctlblk_sel_n; s_addr = ata_addr;
      end
      if (ph == 1) begin if (stb) ph = 2; else su++; end
      if (ph == 2) begin
        if (stb) begin
          if (!ata_rd_n) saw_rd = 1;
          if (!ata_wr_n) begin saw_wr = 1; wd_seen = ata_dout; end
        end else ph = 3;
      end
      if (ph == 3) begin
        if (sel) hd++;
        else begin ph = 0; fin = 1; end
      end
      if (sel && (ata_addr != s_addr || ata_cmdblk_sel_n != s_cmd ||
                  ata_ctlblk_sel_n != s_ctl)) sel_chg = 1;
      if (sel && ata_doe != exp_doe) doe_bad = 1;
      if (!sel && ata_doe) doe_bad = 1;
      if (rsp_done) begin
        done_n++; done_hd = hd; got_err = rsp_err; got_rdata = rsp_rdata;
      end
    end
  end

  task automatic run_op(input bit wr, input bit blk, input logic [2:0] rg,
                        input logic [7:0] dat, input int hold, input bit inject);
    int exp_pw;
    bit exp_err;
    exp_doe = wr; rdy_hold = hold; ata_din = dat; fin = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_blk = blk; cmd_reg = rg; cmd_wdata = dat;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    if (inject) begin
      // R11: requests during a busy access are not taken
      repeat (50) @(negedge clk);
      cmd_valid = 1; cmd_blk = !blk; cmd_reg = ~rg; cmd_write = !wr;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        chk(cmd_ready == 0, "R11 ready low while busy", cmd_ready, 0);
      end
      cmd_valid = 0;
    end
    while (!fin) @(negedge clk);
    if (hold < E_SAMP) begin exp_pw = E_PW; exp_err = 0; end
    else if (hold - E_SAMP + 1 >= LIMIT) begin exp_pw = E_SAMP + LIMIT - 1; exp_err = 1; end
    else begin exp_pw = (hold + 1 > E_PW) ? hold + 1 : E_PW; exp_err = 0; end
    chk(s_cmd == blk && s_ctl == !blk, "R2 block select", {s_cmd, s_ctl}, {blk, !blk});
    chk(s_addr == rg, "R2 address", s_addr, rg);
    chk(!sel_chg, "R2/R11 select stable", sel_chg, 0);
    chk(su == E_SU, "R3 setup cycles", su, E_SU);
    chk(pw == exp_pw, (hold >= E_SAMP) ? "R5/R6 strobe length with wait" : "R4 strobe length",
        pw, exp_pw);
    chk(hd == E_HD, "R7 recovery cycles", hd, E_HD);
    chk((su + pw + hd) * TCK >= TCYC, "R7 total cycle time", (su + pw + hd) * TCK, TCYC);
    chk(saw_wr == wr && saw_rd == !wr, "R8 strobe direction", {saw_wr, saw_rd}, {wr, !wr});
    chk(!doe_bad, "R8 drive enable", doe_bad, 0);
    if (wr) chk(wd_seen == dat, "R8 write data", wd_seen, dat);
    chk(done_n == 1, "R9 single done pulse", done_n, 1);
    chk(done_hd == 2, "R9 done timing", done_hd, 2);
    if (!wr) chk(got_rdata == dat, "R9 read data", got_rdata, dat);
    chk(got_err == exp_err, "R6 error flag", got_err, exp_err);
    chk(!dack_bad, "R10 DMA acknowledge high", dack_bad, 0);
    chk(cmd_ready == 1, "R11 ready after release", cmd_ready, 1);
    repeat (4) @(negedge clk);
    chk(ata_cmdblk_sel_n && ata_ctlblk_sel_n && ph == 0, "R11 no extra access",
        ph, 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk(ata_cmdblk_sel_n && ata_ctlblk_sel_n, "R1 selects idle",
        {ata_cmdblk_sel_n, ata_ctlblk_sel_n}, 3);
    rst = 0;
    @(negedge clk);
    chk(ata_rd_n && ata_wr_n, "R1 strobes idle", {ata_rd_n, ata_wr_n}, 3);
    chk(!ata_doe && dma_ack_n, "R1 drive off, ack high", {ata_doe, dma_ack_n}, 1);
    chk(cmd_ready && !rsp_done, "R1 ready, no done", {cmd_ready, rsp_done}, 2);
  endtask

  initial begin
    test_reset();
    run_op(0, 0, 3'd7, 8'hA5, 0, 0);      // plain read
    run_op(1, 1, 3'd6, 8'h3C, 0, 0);      // plain write, control block
    run_op(0, 1, 3'd2, 8'h5A, 3, 0);      // R5 early low ignored
    run_op(0, 0, 3'd1, 8'hC3, 20, 0);     // R5 wait inside minimum pulse
    run_op(1, 0, 3'd4, 8'h96, 60, 0);     // R5 wait stretches strobe
    run_op(0, 0, 3'd5, 8'h11, 5000, 0);   // R6 stall limit
    run_op(0, 1, 3'd0, 8'hE7, 0, 1);      // R11 request during access
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule